// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a 9-bit first-in-first-out buffer. Its write port and its read port run on two unrelated clocks, and neither clock has to be the faster one. The storage is an inferred register array of `DEPTH` words, with `DEPTH` a power of two. Pointers move between the two domains as Gray codes through two-flop synchronizers. Full, almost-full and half-full are decided in the write domain. Empty and almost-empty are decided in the read domain.

A mode pin is captured during master reset and picks one of two read timings:

- **Standard timing:** each word needs a read request, and `empty_o`/`full_o` mean empty and full.
- **First-word-fall-through (FWFT) timing:** the next word is presented on the output without a request. `empty_o` then means "no valid word on `rdata_o`" and `full_o` means "not ready to accept".

The two almost-flag thresholds come from one of two presets chosen at master reset. They can be reprogrammed later, one bit per write clock on a serial pin or a whole offset at a time from the data bus. Partial reset empties the buffer but keeps the thresholds. Retransmit rewinds the read side to the first location.

Top module: `dc_fifo`

## Requirements
- R1: The mode (`fwft_i`) and the preset choice (`dflt_sel_i`) are captured only on read/write clock edges while `rst_ni` is low. Master reset sets both almost offsets to 7 (`dflt_sel_i`=0) or to 63 (`dflt_sel_i`=1). After master reset: `empty_o`=1, `aempty_o`=1, `full_o`=0, `afull_o`=0, `half_o`=0.
- R2: In standard mode, a read clock edge with `ren_i`=1 and a non-empty buffer loads the oldest word into `rdata_o`. Words come out in write order.
- R3: A word written into an empty buffer at a write edge clears `empty_o` after the second following read edge in standard mode. In FWFT mode it appears on `rdata_o` after the third following read edge.
- R4: The write-domain count is words written minus words taken from storage. `full_o`=1 when the count equals `DEPTH`. `half_o`=1 when the count exceeds `DEPTH/2`. `afull_o`=1 when the count is at least `DEPTH` minus the almost-full offset.
- R5: A write while `full_o`=1 stores nothing and does not disturb stored words.
- R6: In standard mode, a read while `empty_o`=1 changes neither `rdata_o` nor the read position.
- R7: `aempty_o`=1 when the read-domain count is at most the almost-empty offset. In FWFT mode the word held on `rdata_o` counts.
- R8: `rt_i` at a read edge moves the read position back to location 0. In standard mode the next read returns the first word written since the last reset. In FWFT mode `empty_o` is 1 after that edge, and the first word is valid on `rdata_o` after the next edge.
- R9: A write edge with `ld_i`=1 and `wen_i`=1 stores nothing in the buffer. It loads `wdata_i[AW-1:0]` into one offset: the almost-empty offset first, then the almost-full offset, alternating.
- R10: A write edge with `ser_en_i`=1 and `ld_i`=0 shifts `ser_in_i` into the offsets. After 2·AW edges, the first AW bits sent form the almost-empty offset, LSB first, and the next AW bits form the almost-full offset, LSB first.
- R11: Partial reset (`prst_ni` low) empties the buffer and resets the pointers. It keeps the programmed offsets, and the next parallel load targets the almost-empty offset again.
- R12: In FWFT mode, `empty_o`=0 exactly when `rdata_o` holds a valid word. `ren_i` consumes that word.
- R13: With unrelated write and read clock periods, every written word is read out once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, active low, asynchronous for pointers |
| prst_ni | input | 1 | Partial reset, active low |
| fwft_i | input | 1 | Timing mode, 1 = FWFT, captured during master reset |
| dflt_sel_i | input | 1 | Preset select for offsets, captured during master reset |
| wen_i | input | 1 | Write enable |
| wdata_i | input | 9 | Write data, also the parallel offset value |
| ld_i | input | 1 | Steers writes to the offset registers |
| ser_en_i | input | 1 | Serial offset shift enable |
| ser_in_i | input | 1 | Serial offset data |
| ren_i | input | 1 | Read enable |
| rt_i | input | 1 | Retransmit |
| rdata_o | output | 9 | Read data |
| empty_o | output | 1 | Empty (standard) or output not valid (FWFT) |
| aempty_o | output | 1 | Almost empty |
| half_o | output | 1 | More than half full |
| afull_o | output | 1 | Almost full |
| full_o | output | 1 | Full (standard) or not input-ready (FWFT) |

## Verification
Some properties are checked by assertions on every edge:

- a blocked write or a standard-mode read on empty leaves its pointer unchanged;
- full implies both half-full and almost-full;
- standard-mode empty implies almost-empty;
- retransmit lands the read pointer on zero;
- the write Gray pointer changes at most one bit per edge.

Other behaviours need the bench's scenarios: exact crossing latency, data order, the threshold values after serial and parallel loads, offset retention across partial reset, and integrity under unrelated clock rates. The bench follows these with a behavioural model while both clocks share one source, and with a scoreboard while they run at different rates.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int DW = 9;
  localparam int GW = 16;  // widest pointer the helpers handle
  typedef logic [DW-1:0] word_t;

  function automatic logic [GW-1:0] gray2bin(input logic [GW-1:0] g);
    logic [GW-1:0] b;
    b[GW-1] = g[GW-1];
    for (int i = GW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/dcf_offsets.sv
module dcf_offsets #(
  parameter int AW = 7,
  parameter int LO = 7,
  parameter int HI = 63
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          prst_ni,
  input  logic          dflt_sel_i,
  input  logic          ld_i,
  input  logic          wen_i,
  input  logic [AW-1:0] val_i,
  input  logic          ser_en_i,
  input  logic          ser_in_i,
  output logic [AW-1:0] ae_o,
  output logic [AW-1:0] af_o
);
  logic [2*AW-1:0] off_q;  // {almost-full, almost-empty}
  logic            tgt_q;  // 0: next parallel load hits almost-empty

  // sampled on the clock, not async: presets are captured while reset holds
  always_ff @(posedge wclk_i) begin
    if (!rst_ni) begin
      off_q <= dflt_sel_i ? {AW'(HI), AW'(HI)} : {AW'(LO), AW'(LO)};
      tgt_q <= 1'b0;
    end else if (!prst_ni) begin
      tgt_q <= 1'b0;
    end else if (ld_i) begin
      if (wen_i) begin
        if (tgt_q) off_q[2*AW-1:AW] <= val_i;
        else       off_q[AW-1:0]    <= val_i;
        tgt_q <= ~tgt_q;
      end
    end else if (ser_en_i) begin
      off_q <= {ser_in_i, off_q[2*AW-1:1]};
    end
  end

  assign ae_o = off_q[AW-1:0];
  assign af_o = off_q[2*AW-1:AW];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int SYNC  = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wen_i,
  input  logic          ld_i,
  input  logic [PW-1:0] rgray_i,
  input  logic [AW-1:0] af_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wbin_o,
  output logic [PW-1:0] wgray_o,
  output logic          full_o,
  output logic          afull_o,
  output logic          half_o
);
  logic [PW-1:0] wbin_q, wgray_q, rgray_s, rbin_s, wcnt, wbin_n;

  dcf_sync #(.W(PW), .STAGES(SYNC)) u_rsync (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray_i), .q_o(rgray_s)
  );

  assign rbin_s = PW'(gray2bin(GW'(rgray_s)));
  assign wcnt   = wbin_q - rbin_s;
  assign full_o = (wcnt == PW'(DEPTH));
  assign we_o   = wen_i && !ld_i && !full_o;
  assign wbin_n = wbin_q + PW'(we_o);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_n;
      wgray_q <= wbin_n ^ (wbin_n >> 1);
    end
  end

  assign afull_o = {1'b0, wcnt} >= ((PW+1)'(DEPTH) - (PW+1)'(af_i));
  assign half_o  = wcnt > PW'(DEPTH / 2);
  assign waddr_o = wbin_q[AW-1:0];
  assign wbin_o  = wbin_q;
  assign wgray_o = wgray_q;
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int SYNC  = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          ren_i,
  input  logic          rt_i,
  input  logic [PW-1:0] wgray_i,
  input  logic [AW-1:0] ae_i,
  input  word_t         mem_q_i,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] rbin_o,
  output logic [PW-1:0] rgray_o,
  output word_t         rdata_o,
  output logic          empty_o,
  output logic          aempty_o
);
  logic [PW-1:0] rbin_q, rgray_q, wgray_s, wbin_s, rcnt, rbin_n;
  logic          ov_q, avail, adv;
  word_t         rdata_q;

  dcf_sync #(.W(PW), .STAGES(SYNC)) u_wsync (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray_i), .q_o(wgray_s)
  );

  assign wbin_s = PW'(gray2bin(GW'(wgray_s)));
  assign rcnt   = wbin_s - rbin_q;
  assign avail  = (rcnt != '0);
  // std: pop on request; fwft: refill the output word when it is free or consumed
  assign adv    = !rt_i && avail && (fwft_i ? (!ov_q || ren_i) : ren_i);
  assign rbin_n = rt_i ? '0 : rbin_q + PW'(adv);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      rdata_q <= '0;
      ov_q    <= 1'b0;
    end else begin
      rbin_q  <= rbin_n;
      rgray_q <= rbin_n ^ (rbin_n >> 1);
      if (adv) rdata_q <= mem_q_i;
      if (rt_i)                ov_q <= 1'b0;
      else if (adv)            ov_q <= 1'b1;
      else if (ren_i && ov_q)  ov_q <= 1'b0;
    end
  end

  assign empty_o  = fwft_i ? !ov_q : !avail;
  assign aempty_o = ({1'b0, rcnt} + (PW+1)'(fwft_i && ov_q)) <= (PW+1)'(ae_i);
  assign raddr_o  = rbin_q[AW-1:0];
  assign rbin_o   = rbin_q;
  assign rgray_o  = rgray_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/dc_fifo.sv
module dc_fifo
  import dcf_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DFLT_LO = 7,
  parameter int DFLT_HI = 63,
  parameter int SYNC   = 2
) (
  input  logic        wclk_i,
  input  logic        rclk_i,
  input  logic        rst_ni,
  input  logic        prst_ni,
  input  logic        fwft_i,
  input  logic        dflt_sel_i,
  input  logic        wen_i,
  input  logic [8:0]  wdata_i,
  input  logic        ld_i,
  input  logic        ser_en_i,
  input  logic        ser_in_i,
  input  logic        ren_i,
  input  logic        rt_i,
  output logic [8:0]  rdata_o,
  output logic        empty_o,
  output logic        aempty_o,
  output logic        half_o,
  output logic        afull_o,
  output logic        full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          wrst_n, rrst_n, we, mode_q;
  logic [AW-1:0] waddr, raddr, ae_off, af_off;
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  word_t         mem [DEPTH];
  word_t         mem_q;

  assign wrst_n = rst_ni & prst_ni;
  assign rrst_n = rst_ni & prst_ni;

  // timing mode is only captured while master reset holds
  always_ff @(posedge rclk_i) begin
    if (!rst_ni) mode_q <= fwft_i;
  end

  dcf_offsets #(.AW(AW), .LO(DFLT_LO), .HI(DFLT_HI)) u_off (
    .wclk_i(wclk_i), .rst_ni(rst_ni), .prst_ni(prst_ni), .dflt_sel_i(dflt_sel_i),
    .ld_i(ld_i), .wen_i(wen_i), .val_i(wdata_i[AW-1:0]),
    .ser_en_i(ser_en_i), .ser_in_i(ser_in_i), .ae_o(ae_off), .af_o(af_off)
  );

  dcf_wr_ctrl #(.DEPTH(DEPTH), .SYNC(SYNC)) u_wr (
    .wclk_i(wclk_i), .rst_ni(wrst_n), .wen_i(wen_i), .ld_i(ld_i),
    .rgray_i(rgray), .af_i(af_off), .we_o(we), .waddr_o(waddr),
    .wbin_o(wbin), .wgray_o(wgray), .full_o(full_o), .afull_o(afull_o),
    .half_o(half_o)
  );

  always_ff @(posedge wclk_i) begin
    if (we) mem[waddr] <= wdata_i;
  end
  assign mem_q = mem[raddr];

  dcf_rd_ctrl #(.DEPTH(DEPTH), .SYNC(SYNC)) u_rd (
    .rclk_i(rclk_i), .rst_ni(rrst_n), .fwft_i(mode_q), .ren_i(ren_i),
    .rt_i(rt_i), .wgray_i(wgray), .ae_i(ae_off), .mem_q_i(mem_q),
    .raddr_o(raddr), .rbin_o(rbin), .rgray_o(rgray), .rdata_o(rdata_o),
    .empty_o(empty_o), .aempty_o(aempty_o)
  );
endmodule

// File: rtl/dc_fifo_chk.sv
module dc_fifo_chk #(
  parameter int PW = 8
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          wrst_ni,
  input logic          rrst_ni,
  input logic          mode_i,
  input logic          wen_i,
  input logic          ld_i,
  input logic          ren_i,
  input logic          rt_i,
  input logic          full_i,
  input logic          half_i,
  input logic          afull_i,
  input logic          empty_i,
  input logic          aempty_i,
  input logic [PW-1:0] wbin_i,
  input logic [PW-1:0] wgray_i,
  input logic [PW-1:0] rbin_i
);
  a_r5_no_overflow: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (full_i && wen_i && !ld_i) |=> (wbin_i == $past(wbin_i)));

  a_r4_full_afull: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    full_i |-> afull_i);

  a_r4_full_half: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    full_i |-> half_i);

  a_r13_gray_step: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    $countones(wgray_i ^ $past(wgray_i)) <= 1);

  a_r6_no_underflow: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (!mode_i && empty_i && ren_i && !rt_i) |=> (rbin_i == $past(rbin_i)));

  a_r7_empty_aempty: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (!mode_i && empty_i) |-> aempty_i);

  a_r8_rt_rewind: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    rt_i |=> (rbin_i == '0));
endmodule

bind dc_fifo dc_fifo_chk #(.PW(PW)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .wrst_ni(wrst_n), .rrst_ni(rrst_n),
  .mode_i(mode_q), .wen_i(wen_i), .ld_i(ld_i), .ren_i(ren_i), .rt_i(rt_i),
  .full_i(full_o), .half_i(half_o), .afull_i(afull_o), .empty_i(empty_o),
  .aempty_i(aempty_o), .wbin_i(wbin), .wgray_i(wgray), .rbin_i(rbin)
);

// File: tb/sim_dc_fifo.sv
module sim_dc_fifo;
  localparam int D = 128;
  localparam int M = 2 * D;

  logic clk = 0, clk2 = 0, async_ph = 0;
  always #4 clk = ~clk;    // 125 MHz
  always #6 clk2 = ~clk2;  // unrelated read clock for R13
  logic rclk;
  assign rclk = async_ph ? clk2 : clk;

  logic       rst_n = 0, prst_n = 1, fwft = 0, dsel = 0;
  logic       wen = 0, ld = 0, ser_en = 0, ser_in = 0, ren = 0, rt = 0;
  logic [8:0] wdata = 0;
  logic [8:0] rdata;
  logic       empty, aempty, half, afull, full;

  dc_fifo #(.DEPTH(D)) u0 (
    .wclk_i(clk), .rclk_i(rclk), .rst_ni(rst_n), .prst_ni(prst_n),
    .fwft_i(fwft), .dflt_sel_i(dsel), .wen_i(wen), .wdata_i(wdata),
    .ld_i(ld), .ser_en_i(ser_en), .ser_in_i(ser_in), .ren_i(ren), .rt_i(rt),
    .rdata_o(rdata), .empty_o(empty), .aempty_o(aempty), .half_o(half),
    .afull_o(afull), .full_o(full)
  );

  int n_chk = 0, n_bad = 0;
  bit cmp_en = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference (valid while both clocks share clk)
  int m_wp = 0, m_rp = 0, m_ws1 = 0, m_ws2 = 0, m_rs1 = 0, m_rs2 = 0;
  int m_ov = 0, m_dout = 0, m_mode = 0, m_ae = 7, m_af = 7, m_sel = 0;
  int m_mem[D];

  function automatic int dif(input int a, input int b);
    return ((a - b) % M + M) % M;
  endfunction

  always @(posedge clk) begin : model
    int wp0, rp0, ws0, rs0, cnt, v;
    wp0 = m_wp; rp0 = m_rp; ws0 = m_ws2; rs0 = m_rs2;
    if (!rst_n) begin
      m_mode = fwft;
      m_ae = dsel ? 63 : 7;
      m_af = m_ae;
    end
    if (!rst_n || !prst_n) begin
      m_wp = 0; m_rp = 0; m_ws1 = 0; m_ws2 = 0; m_rs1 = 0; m_rs2 = 0;
      m_ov = 0; m_dout = 0; m_sel = 0;
    end else begin
      if (ld) begin
        if (wen) begin
          if (m_sel == 1) m_af = wdata % 128; else m_ae = wdata % 128;
          m_sel = 1 - m_sel;
        end
      end else begin
        if (ser_en) begin
          v = m_af * 128 + m_ae;
          v = (v >> 1) | (int'(ser_in) << 13);
          m_ae = v % 128; m_af = v / 128;
        end
        if (wen && dif(wp0, rs0) != D) begin
          m_mem[wp0 % D] = wdata;
          m_wp = (wp0 + 1) % M;
        end
      end
      cnt = dif(ws0, rp0);
      if (rt) begin
        m_rp = 0;
        if (m_mode == 1) m_ov = 0;
      end else if (m_mode == 0) begin
        if (ren && cnt != 0) begin m_dout = m_mem[rp0 % D]; m_rp = (rp0 + 1) % M; end
      end else if ((m_ov == 0 || ren) && cnt != 0) begin
        m_dout = m_mem[rp0 % D]; m_rp = (rp0 + 1) % M; m_ov = 1;
      end else if (ren && m_ov == 1) m_ov = 0;
      m_ws2 = m_ws1; m_ws1 = wp0; m_rs2 = m_rs1; m_rs1 = rp0;
    end
  end

  always @(negedge clk) begin : compare
    int wc, rc;
    if (cmp_en && !async_ph) begin
      wc = dif(m_wp, m_rs2);
      rc = dif(m_ws2, m_rp);
      chk(full == (wc == D), "R4 full", full, wc == D);
      chk(afull == (wc >= D - m_af), "R4 afull", afull, wc >= D - m_af);
      chk(half == (wc > D / 2), "R4 half", half, wc > D / 2);
      if (m_mode == 1) chk(empty == (m_ov == 0), "R12 empty", empty, m_ov == 0);
      else             chk(empty == (rc == 0), "R3 empty", empty, rc == 0);
      chk(aempty == (rc + (m_mode == 1 ? m_ov : 0) <= m_ae), "R7 aempty",
          aempty, rc + (m_mode == 1 ? m_ov : 0) <= m_ae);
      if (m_mode == 0 || m_ov == 1) chk(rdata == m_dout, "R2 rdata", rdata, m_dout);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wen = 1; wdata = 9'((base + i) % 512);
    end
    @(negedge clk);
    wen = 0;
  endtask

  task automatic rd(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ren = 1;
    end
    @(negedge clk);
    ren = 0;
  endtask

  task automatic mreset(input bit sel, input bit mode, input bit asy);
    @(negedge clk);
    cmp_en = 0; rst_n = 0; dsel = sel; fwft = mode;
    idle(3);
    async_ph = asy;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    cmp_en = 1;
  endtask

  task automatic preset();
    @(negedge clk);
    cmp_en = 0; prst_n = 0;
    idle(2);
    prst_n = 1;
    @(negedge clk);
    cmp_en = 1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int n, idx, wcnt;
    int bits;
    mreset(0, 0, 0);
    // R1 reset state
    chk(empty == 1, "R1 empty", empty, 1);
    chk(full == 0, "R1 full", full, 0);
    chk(aempty == 1, "R1 aempty", aempty, 1);
    chk(afull == 0, "R1 afull", afull, 0);
    chk(half == 0, "R1 half", half, 0);

    // R3 standard latency
    wr(1, 5);
    chk(empty == 1, "R3 empty k", empty, 1);
    @(negedge clk); chk(empty == 1, "R3 empty k+1", empty, 1);
    @(negedge clk); chk(empty == 0, "R3 empty k+2", empty, 0);
    rd(1);
    chk(rdata == 5, "R2 first word", rdata, 5);
    chk(empty == 1, "R2 empty after pop", empty, 1);
    rd(3);
    chk(rdata == 5, "R6 rdata held", rdata, 5);
    chk(empty == 1, "R6 still empty", empty, 1);

    // R5 overfill then drain
    wr(130, 0);
    idle(4);
    chk(full == 1, "R4 full at depth", full, 1);
    n = 0;
    while (!empty && n < 300) begin
      ren = 1;
      @(negedge clk);
      n++;
    end
    ren = 0;
    chk(n == D, "R5 words stored", n, D);
    chk(rdata == 127, "R5 last word", rdata, 127);

    // R8 retransmit, standard
    preset();
    wr(5, 100);
    idle(3);
    rd(2);
    chk(rdata == 101, "R2 second word", rdata, 101);
    rt = 1;
    @(negedge clk);
    rt = 0; ren = 1;
    @(negedge clk);
    ren = 0;
    chk(rdata == 100, "R8 rewind std", rdata, 100);

    // R9 parallel load: ae=20, af=30
    preset();
    @(negedge clk); ld = 1; wen = 1; wdata = 20;
    @(negedge clk); wdata = 30;
    @(negedge clk); ld = 0; wen = 0;
    idle(3);
    chk(empty == 1, "R9 no data stored", empty, 1);
    wr(97, 0);
    idle(3);
    chk(afull == 0, "R9 afull below", afull, 0);
    wr(1, 97);
    chk(afull == 1, "R9 afull at 98", afull, 1);
    idle(3);
    chk(aempty == 0, "R9 aempty", aempty, 0);

    // R11 partial reset keeps offsets
    preset();
    wr(97, 0);
    idle(3);
    chk(afull == 0, "R11 afull below", afull, 0);
    wr(1, 97);
    chk(afull == 1, "R11 kept threshold", afull, 1);

    // R10 serial load: ae=5, af=10
    preset();
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      bits = (i < 7) ? ((5 >> i) & 1) : ((10 >> (i - 7)) & 1);
      ser_en = 1; ser_in = bits[0];
    end
    @(negedge clk); ser_en = 0;
    wr(117, 0);
    idle(2);
    chk(afull == 0, "R10 afull below", afull, 0);
    wr(1, 117);
    chk(afull == 1, "R10 afull at 118", afull, 1);
    rd(112);
    idle(2);
    chk(aempty == 0, "R10 aempty at 6", aempty, 0);
    rd(1);
    chk(aempty == 1, "R10 aempty at 5", aempty, 1);

    // FWFT, preset 63
    mreset(1, 1, 0);
    wr(1, 77);
    chk(empty == 1, "R3 fwft k", empty, 1);
    @(negedge clk); chk(empty == 1, "R3 fwft k+1", empty, 1);
    @(negedge clk); chk(empty == 1, "R3 fwft k+2", empty, 1);
    @(negedge clk);
    chk(empty == 0, "R12 valid k+3", empty, 0);
    chk(rdata == 77, "R12 fall-through", rdata, 77);
    rd(1);
    chk(empty == 1, "R12 consumed", empty, 1);
    wr(63, 200);
    idle(5);
    chk(aempty == 1, "R7 aempty at 63", aempty, 1);
    chk(rdata == 200, "R12 head word", rdata, 200);
    wr(2, 263);
    idle(5);
    chk(aempty == 0, "R7 aempty at 65", aempty, 0);
    chk(afull == 0, "R1 preset 63 below", afull, 0);
    wr(1, 265);
    idle(3);
    chk(afull == 1, "R1 preset 63", afull, 1);
    @(negedge clk); rt = 1;
    @(negedge clk); rt = 0;
    chk(empty == 1, "R8 fwft after rt", empty, 1);
    @(negedge clk);
    chk(empty == 0, "R8 fwft refill", empty, 0);
    chk(rdata == 77, "R8 fwft first word", rdata, 77);

    // R13 unrelated clocks, standard mode
    mreset(0, 0, 1);
    idx = 0;
    fork
      begin
        wcnt = 0;
        while (wcnt < 40) begin
          @(negedge clk);
          if (!full) begin wen = 1; wdata = 9'(300 + wcnt); wcnt++; end
          else wen = 0;
        end
        @(negedge clk); wen = 0;
      end
      begin
        bit pend;
        pend = 0;
        for (int t = 0; t < 3000 && idx < 40; t++) begin
          @(negedge clk2);
          if (pend) begin
            chk(rdata == 9'(300 + idx), "R13 order", rdata, 300 + idx);
            idx++;
            pend = 0;
          end
          if (!empty && idx < 40) begin ren = 1; pend = 1; end
          else ren = 0;
        end
        ren = 0;
      end
    join
    chk(idx == 40, "R13 all words", idx, 40);

    done = 1;
    summary();
    $finish;
  end
endmodule